// File: doc/BRIEF.md
# GPIO Edge Interrupt Cause Unit

This unit watches up to 32 already-synchronized GPIO inputs for edges. Each pin has its own rising-edge enable and falling-edge enable, and setting both makes the pin sensitive to either edge. An enabled edge sets that pin's bit in a sticky cause register. The bit stays set until software writes a one to the matching bit of a write-one-to-clear register.

A separate per-pin event mask decides which pending causes reach the single level-sensitive interrupt output. The output is high while any pin has both its cause bit and its mask bit set. A dedicated read offset returns the pending causes ANDed with the mask. An interrupt handler can write that value straight back to the clear register, which acknowledges exactly the events it is about to service.

All state is reached through a simple 32-bit register port. A write takes effect at the clock edge on which `bus_wr` is sampled high, and reads are combinational from the address.

Top module: `gpio_edge_cause`

## Requirements
- R1: Rise enable (offset 0x44), fall enable (0x48) and event mask (0x94) are read/write, one bit per pin at bit position = pin index; a write is visible on a read in the following cycle.
- R2: With its rise-enable bit set, a pin sampled 0 on one clock edge and 1 on the next sets its cause bit at that second edge.
- R3: With its fall-enable bit set, a pin sampled 1 then 0 on consecutive clock edges sets its cause bit at the second edge; with both enable bits set, either edge sets it.
- R4: Cause bits are sticky: once set, they stay set until cleared, whether or not the pin's mask bit is set.
- R5: Writing offset 0x98 clears each cause bit whose data bit is 1; zero bits leave causes unchanged; an edge detected in the same cycle as the clear keeps the bit set.
- R6: Offset 0x80 reads cause AND event mask.
- R7: `irq` is high exactly while cause AND mask is non-zero, following the registers without added delay.
- R8: After reset, all enables, the mask and all causes read zero and `irq` is low.
- R9: Bits at positions NPINS and above read zero in every register and never set a cause.
- R10: Writes to 0x80 or to unmapped offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 32 | Synchronized GPIO input levels |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` |
| irq | output | 1 | Level interrupt: OR of masked pending causes |

## Verification
On every cycle, the assertions check that enabled rising and falling edges latch, that causes persist unless cleared, that a clear without a coincident edge empties the bit, that a zero mask keeps `irq` low, and that unimplemented bits stay zero. Only the bench scenarios can show the register map and read-back values, that a cause latched while masked surfaces once the mask is opened, the same-cycle race between an edge and a clear, and that writes to read-only or unmapped offsets are ignored. The bench sweeps every pin of an 8-pin build through all four enable combinations in both edge directions.

// File: rtl/gpio_edge_cause.sv
module gpio_edge_cause #(
  parameter int NPINS = 32,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   pin_in,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          irq
);
  localparam logic [31:0]   PMASK     = 32'((64'h1 << NPINS) - 64'h1);
  localparam logic [AW-1:0] OFF_RISE  = AW'(8'h44);
  localparam logic [AW-1:0] OFF_FALL  = AW'(8'h48);
  localparam logic [AW-1:0] OFF_PEND  = AW'(8'h80);
  localparam logic [AW-1:0] OFF_MASK  = AW'(8'h94);
  localparam logic [AW-1:0] OFF_CLR   = AW'(8'h98);

  logic [31:0] rise_en_q, fall_en_q, evt_mask_q, cause_q, pin_prev_q;
  logic [31:0] pins, edge_hit, clr_bits, pending;

  assign pins     = pin_in & PMASK;
  assign edge_hit = (pins & ~pin_prev_q & rise_en_q) | (~pins & pin_prev_q & fall_en_q);
  assign clr_bits = (bus_wr && bus_addr == OFF_CLR) ? (bus_wdata & PMASK) : 32'h0;
  assign pending  = cause_q & evt_mask_q;
  assign irq      = |pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_en_q  <= '0;
      fall_en_q  <= '0;
      evt_mask_q <= '0;
      cause_q    <= '0;
      pin_prev_q <= '0;
    end else begin
      pin_prev_q <= pins;
      cause_q    <= (cause_q & ~clr_bits) | edge_hit;
      if (bus_wr) begin
        case (bus_addr)
          OFF_RISE: rise_en_q  <= bus_wdata & PMASK;
          OFF_FALL: fall_en_q  <= bus_wdata & PMASK;
          OFF_MASK: evt_mask_q <= bus_wdata & PMASK;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (bus_addr)
      OFF_RISE: bus_rdata = rise_en_q;
      OFF_FALL: bus_rdata = fall_en_q;
      OFF_PEND: bus_rdata = pending;
      OFF_MASK: bus_rdata = evt_mask_q;
      default:  bus_rdata = 32'h0;
    endcase
  end
endmodule

// File: rtl/gpio_edge_cause_chk.sv
module gpio_edge_cause_chk #(
  parameter int NPINS = 32,
  parameter int AW    = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [31:0]   pin_in,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [31:0]   bus_wdata,
  input logic          irq,
  input logic [31:0]   rise_en_q,
  input logic [31:0]   fall_en_q,
  input logic [31:0]   evt_mask_q,
  input logic [31:0]   cause_q,
  input logic [31:0]   pin_prev_q
);
  localparam logic [31:0] PMASK = 32'((64'h1 << NPINS) - 64'h1);

  logic [31:0] hit_r, hit_f, clr_v;
  assign hit_r = pin_in & PMASK & ~pin_prev_q & rise_en_q;
  assign hit_f = ~pin_in & PMASK & pin_prev_q & fall_en_q;
  assign clr_v = (bus_wr && bus_addr == AW'(8'h98)) ? bus_wdata : 32'h0;

  assert_rise_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_r != 0) |=> ((cause_q & $past(hit_r)) == $past(hit_r)));

  assert_fall_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_f != 0) |=> ((cause_q & $past(hit_f)) == $past(hit_f)));

  assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_q != 0) |=> (($past(cause_q) & ~$past(clr_v) & ~cause_q) == 0));

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_v != 0) |=> ((cause_q & $past(clr_v & ~(hit_r | hit_f))) == 0));

  assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_mask_q == 0) |-> !irq);

  assert_unused_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((cause_q | evt_mask_q | rise_en_q | fall_en_q) & ~PMASK) == 0);
endmodule

bind gpio_edge_cause gpio_edge_cause_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq(irq),
  .rise_en_q(rise_en_q), .fall_en_q(fall_en_q), .evt_mask_q(evt_mask_q),
  .cause_q(cause_q), .pin_prev_q(pin_prev_q)
);

// File: tb/gpio_edge_cause_bench.sv
module gpio_edge_cause_bench;
  localparam int NP = 8;
  localparam logic [31:0] PM = 32'hFF;

  logic        clk = 0, rst_n = 0, bus_wr = 0, irq;
  logic [31:0] pin_in = 0, bus_wdata = 0, bus_rdata;
  logic [7:0]  bus_addr = 0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_edge_cause #(.NPINS(NP), .AW(8)) u_gpio_edge_cause (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #0.5; d = bus_rdata;
  endtask

  task automatic set_pins(input logic [31:0] v);
    @(negedge clk); pin_in = v; @(negedge clk);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      summary();
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R8: reset state
    foreach (v[i]) ;
    rd(8'h44, v); chk("R8 rise", v, 0);
    rd(8'h48, v); chk("R8 fall", v, 0);
    rd(8'h94, v); chk("R8 mask", v, 0);
    rd(8'h80, v); chk("R8 pend", v, 0);
    chk("R8 irq", {31'b0, irq}, 0);
    rst_n = 1;

    // R1 / R9: readback, upper bits read zero
    wr(8'h44, 32'hFFFF_FFA5); rd(8'h44, v); chk("R1 R9 rise", v, 32'hA5);
    wr(8'h48, 32'h1234_565A); rd(8'h48, v); chk("R1 R9 fall", v, 32'h5A);
    wr(8'h94, 32'hFFFF_FF0F); rd(8'h94, v); chk("R1 R9 mask", v, 32'h0F);

    // R2 R3 R6 R7: sweep pins x enable combos x directions
    for (int p = 0; p < NP; p++) begin
      for (int e = 0; e < 4; e++) begin
        set_pins(0);
        wr(8'h44, e[0] ? (32'h1 << p) : 0);
        wr(8'h48, e[1] ? (32'h1 << p) : 0);
        wr(8'h94, PM);
        wr(8'h98, PM);
        set_pins(32'h1 << p);
        rd(8'h80, v); chk("R2 rise sweep", v, e[0] ? (32'h1 << p) : 0);
        chk("R7 irq rise", {31'b0, irq}, {31'b0, e[0]});
        wr(8'h98, PM);
        set_pins(0);
        rd(8'h80, v); chk("R3 fall sweep", v, e[1] ? (32'h1 << p) : 0);
        chk("R7 irq fall", {31'b0, irq}, {31'b0, e[1]});
      end
    end

    // R9: upper pins never set a cause
    wr(8'h44, 32'hFFFF_FFFF); wr(8'h48, 32'hFFFF_FFFF); wr(8'h94, 32'hFFFF_FFFF);
    wr(8'h98, 32'hFFFF_FFFF);
    set_pins(32'hFFFF_FF00); set_pins(0);
    rd(8'h80, v); chk("R9 upper pins", v, 0);

    // R4 R6 R7: latch while masked, exposed later
    wr(8'h94, 0);
    set_pins(32'h0000_0009);
    rd(8'h80, v); chk("R6 masked pend", v, 0);
    chk("R4 irq masked", {31'b0, irq}, 0);
    repeat (5) @(negedge clk);
    wr(8'h94, 32'h08);
    rd(8'h80, v); chk("R4 sticky exposed", v, 32'h08);
    chk("R7 irq exposed", {31'b0, irq}, 1);
    wr(8'h94, PM);
    rd(8'h80, v); chk("R4 both pend", v, 32'h09);

    // R5: zero bits have no effect, partial clear
    wr(8'h98, 32'h01);
    rd(8'h80, v); chk("R5 partial clear", v, 32'h08);
    wr(8'h98, 32'h08);
    rd(8'h80, v); chk("R5 full clear", v, 0);
    chk("R7 irq cleared", {31'b0, irq}, 0);

    // R5: edge coincident with clear wins
    wr(8'h48, 0);
    set_pins(32'h04);
    rd(8'h80, v); chk("R5 setup", v, 32'h04);
    set_pins(0);
    @(negedge clk); pin_in = 32'h04; bus_wr = 1; bus_addr = 8'h98; bus_wdata = 32'h04;
    @(negedge clk); bus_wr = 0;
    rd(8'h80, v); chk("R5 edge wins", v, 32'h04);

    // R10: writes to read-only and unmapped offsets ignored
    wr(8'h80, 32'h0); wr(8'h00, 32'h0); wr(8'h4C, 32'h0);
    rd(8'h80, v); chk("R10 pend kept", v, 32'h04);
    rd(8'h44, v); chk("R10 rise kept", v, PM);
    rd(8'h94, v); chk("R10 mask kept", v, PM);

    done = 1;
    summary();
  end
endmodule